// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Register

This block holds the status word of one serial channel. It shows five live FIFO flags, taken straight from the FIFO counts and the programmed thresholds. It also keeps seven sticky event bits. Each event bit is set by a condition seen on the channel: a transmitted message has completed, a received message has ended, a FIFO level crossing has occurred, or a DMA fault has been reported.

End of a received message is found by watching the receive line. After at least one byte has arrived, the line must stay at its idle level (logic 1) for a run of bit-period ticks. The two FIFO threshold events fire only when the count enters the threshold condition, not while it stays there.

Software clears an event by writing a 1 to its bit position. A second write target loads an enable mask. The interrupt request is active while any enabled event is set.

Top module: `chan_status_irq`

## Requirements
- R1: A one-cycle `tx_msg_done` pulse sets status bit 8 on the next clock edge, and the bit stays set.
- R2: Status bit 9 sets on the edge where the eighth `bit_tick` is sampled with `rx_line` high since the last `rx_byte_done`. A low `rx_line` or a new `rx_byte_done` restarts the count. Ticks seen before any byte, or after a completed message, never set it.
- R3: Status bit 10 sets when `tx_count <= tx_ae_level` becomes true after being false. While the condition stays true, the bit does not set again. After reset the condition counts as already true.
- R4: Status bit 11 sets when `rx_count >= rx_af_level` becomes true after being false. While the count stays at or above the level, the bit does not set again after it is cleared.
- R5: Status bits 12, 13 and 14 set on pulses of `dma_tgt_abort`, `dma_mst_abort` and `dma_dir_err` respectively.
- R6: Live bits are combinational:
  - bit0 = (`tx_count`==0)
  - bit1 = (`tx_count`<=`tx_ae_level`)
  - bit2 = (`rx_count`==0)
  - bit3 = (`rx_count`>=`rx_af_level`)
  - bit4 = (`rx_count`==FIFO_DEPTH)
  - bits 5, 6, 7 and 15 read 0.
- R7: A write with `wr_sel`=0 clears each bit in 14:8 where `wr_data` holds 1. Bits where `wr_data` holds 0 are unchanged.
- R8: If an event and its clear fall in the same cycle, the bit ends up set.
- R9: A write with `wr_sel`=1 loads `wr_data[14:8]` into the enable mask. `irq` equals the OR over bits 14:8 of (event bit AND mask bit).
- R10: After synchronous reset, bits 14:8, the enable mask and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_msg_done | input | 1 | Transmit message complete pulse |
| rx_line | input | 1 | Receive serial line, idle high |
| rx_byte_done | input | 1 | Receive byte complete pulse |
| bit_tick | input | 1 | One pulse per bit period |
| tx_count | input | CNT_W | TX FIFO word count |
| rx_count | input | CNT_W | RX FIFO word count |
| tx_ae_level | input | CNT_W | TX almost-empty threshold |
| rx_af_level | input | CNT_W | RX almost-full threshold |
| dma_tgt_abort | input | 1 | DMA target abort pulse |
| dma_mst_abort | input | 1 | DMA master abort pulse |
| dma_dir_err | input | 1 | Descriptor direction error pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status clear, 1 enable mask |
| wr_data | input | 16 | Write data |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that collide are the setting of a sticky event and a write-one-to-clear of the same bit. The bench provokes this by pulsing `tx_msg_done` in the very cycle that a status write clears bit 8, with the bit already set. The bit must read back as 1 afterwards. A behavioural model, updated on every edge, judges each cycle together with targeted checks.

// File: rtl/chan_stat_pkg.sv
// Package: shared bit positions and write-target codes for the channel
// status register. Assumes a 16-bit status word with events in 14:8.
package chan_stat_pkg;
    localparam int STATUS_W  = 16;
    localparam int EVT_LSB   = 8;
    localparam int EVT_N     = 7;
    // Live flag positions
    localparam int LV_TX_EMPTY  = 0;
    localparam int LV_TX_LOW    = 1;
    localparam int LV_RX_EMPTY  = 2;
    localparam int LV_RX_HIGH   = 3;
    localparam int LV_RX_FULL   = 4;
    // Event indices inside the event vector (add EVT_LSB for status bit)
    localparam int EV_TX_DONE   = 0;
    localparam int EV_RX_DONE   = 1;
    localparam int EV_TX_LOW    = 2;
    localparam int EV_RX_HIGH   = 3;
    localparam int EV_DMA_TGT   = 4;
    localparam int EV_DMA_MST   = 5;
    localparam int EV_DMA_DIR   = 6;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } wr_target_e;
endpackage

// File: rtl/rx_idle_detect.sv
// Module: rx_idle_detect
// Declares end of a received message once a byte has arrived and the line
// has then stayed high for IDLE_BITS bit ticks. Assumes bit_tick is a
// single-cycle pulse and rx_line is already synchronised.
module rx_idle_detect #(
    parameter int IDLE_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    input  logic rx_byte_done,
    input  logic bit_tick,
    output logic msg_end
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);

    logic             armed;
    logic [CNT_W-1:0] idle_cnt;

    // Final idle tick of an armed run (a byte arriving this cycle cancels it)
    assign msg_end = armed && rx_line && bit_tick && !rx_byte_done
                     && (idle_cnt == CNT_W'(IDLE_BITS - 1));

    // Track arming and count idle ticks; restart on activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            idle_cnt <= '0;
        end else if (rx_byte_done) begin
            armed    <= 1'b1;
            idle_cnt <= '0;
        end else if (!rx_line) begin
            idle_cnt <= '0;
        end else if (msg_end) begin
            armed    <= 1'b0;
            idle_cnt <= '0;
        end else if (armed && bit_tick) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R2: a completed message disarms, so no back-to-back end pulses
    p_no_repeat_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_end |=> !msg_end);

    // R2: a low line restarts the run, so no end on the next cycle
    p_low_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_line && !rx_byte_done) |=> !msg_end);
endmodule

// File: rtl/level_cross.sv
// Module: level_cross
// Flags the cycle in which a FIFO count enters its threshold condition.
// AT_OR_BELOW=1 tests count<=level, otherwise count>=level. Assumes that
// after reset the condition is treated as already met (no event from reset).
module level_cross #(
    parameter int CNT_W       = 5,
    parameter bit AT_OR_BELOW = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    output logic             in_zone,
    output logic             entered
);
    logic was_in;

    // Select the comparison direction
    generate
        if (AT_OR_BELOW) begin : g_below
            assign in_zone = (count <= level);
        end else begin : g_above
            assign in_zone = (count >= level);
        end
    endgenerate

    assign entered = in_zone && !was_in;

    // Remember last cycle's condition for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) was_in <= 1'b1;
        else        was_in <= in_zone;
    end

    // R3 and R4: an entry cannot repeat on the following cycle
    p_single_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        entered |=> !entered);
endmodule

// File: rtl/sticky_bank.sv
// Module: sticky_bank
// Bank of N sticky event bits with write-one-to-clear, a loadable enable
// mask and the combined interrupt request. Set beats clear in a shared cycle.
module sticky_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_ev,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_data,
    output logic [N-1:0] ev_q,
    output logic [N-1:0] mask_q,
    output logic         irq
);
    // One flop per event bit
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            // Set has priority over clear; otherwise hold
            always_ff @(posedge clk) begin
                if (!rst_n)         ev_q[i] <= 1'b0;
                else if (set_ev[i]) ev_q[i] <= 1'b1;
                else if (clr_ev[i]) ev_q[i] <= 1'b0;
            end

            p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
                set_ev[i] |=> ev_q[i]);
            p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_ev[i] && !set_ev[i]) |=> !ev_q[i]);
            p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_ev[i] && !set_ev[i]) |=> $stable(ev_q[i]));
        end
    endgenerate

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_data;
    end

    assign irq = |(ev_q & mask_q);

    // R9: request only with some event pending
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ev_q != '0));
    // R9: an all-zero mask written keeps the request quiet next cycle
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_data == '0 && !$isunknown(mask_data)) |=> !irq);
endmodule

// File: rtl/chan_status_irq.sv
// Module: chan_status_irq (top)
// Status word and interrupt request for one serial channel: live FIFO flags,
// sticky events, write-one-to-clear and an enable mask. Assumes all input
// pulses are single-cycle and synchronous to clk.
module chan_status_irq
    import chan_stat_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int IDLE_BITS  = 8,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_msg_done,
    input  logic                rx_line,
    input  logic                rx_byte_done,
    input  logic                bit_tick,
    input  logic [CNT_W-1:0]    tx_count,
    input  logic [CNT_W-1:0]    rx_count,
    input  logic [CNT_W-1:0]    tx_ae_level,
    input  logic [CNT_W-1:0]    rx_af_level,
    input  logic                dma_tgt_abort,
    input  logic                dma_mst_abort,
    input  logic                dma_dir_err,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [STATUS_W-1:0] wr_data,
    output logic [STATUS_W-1:0] status,
    output logic                irq
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    logic             rx_end;
    logic             tx_low, tx_low_enter;
    logic             rx_high, rx_high_enter;
    logic [EVT_N-1:0] set_ev, clr_ev, ev_q, mask_q;
    logic             wr_status, wr_mask;

    assign wr_status = wr_en && (wr_sel == SEL_STATUS);
    assign wr_mask   = wr_en && (wr_sel == SEL_MASK);

    rx_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .rx_byte_done(rx_byte_done), .bit_tick(bit_tick), .msg_end(rx_end)
    );

    level_cross #(.CNT_W(CNT_W), .AT_OR_BELOW(1'b1)) u_tx_low (
        .clk(clk), .rst_n(rst_n), .count(tx_count), .level(tx_ae_level),
        .in_zone(tx_low), .entered(tx_low_enter)
    );

    level_cross #(.CNT_W(CNT_W), .AT_OR_BELOW(1'b0)) u_rx_high (
        .clk(clk), .rst_n(rst_n), .count(rx_count), .level(rx_af_level),
        .in_zone(rx_high), .entered(rx_high_enter)
    );

    // Gather set and clear requests for the event bank
    always_comb begin
        set_ev             = '0;
        set_ev[EV_TX_DONE] = tx_msg_done;
        set_ev[EV_RX_DONE] = rx_end;
        set_ev[EV_TX_LOW]  = tx_low_enter;
        set_ev[EV_RX_HIGH] = rx_high_enter;
        set_ev[EV_DMA_TGT] = dma_tgt_abort;
        set_ev[EV_DMA_MST] = dma_mst_abort;
        set_ev[EV_DMA_DIR] = dma_dir_err;
        clr_ev = wr_status ? wr_data[EVT_LSB +: EVT_N] : '0;
    end

    sticky_bank #(.N(EVT_N)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev),
        .mask_wr(wr_mask), .mask_data(wr_data[EVT_LSB +: EVT_N]),
        .ev_q(ev_q), .mask_q(mask_q), .irq(irq)
    );

    // Assemble the status word from live flags and latched events
    always_comb begin
        status                   = '0;
        status[LV_TX_EMPTY]      = (tx_count == '0);
        status[LV_TX_LOW]        = tx_low;
        status[LV_RX_EMPTY]      = (rx_count == '0);
        status[LV_RX_HIGH]       = rx_high;
        status[LV_RX_FULL]       = (rx_count == FULL_CNT);
        status[EVT_LSB +: EVT_N] = ev_q;
    end

    // R1: a message-done pulse is visible in the status word next cycle
    p_tx_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_msg_done |=> status[EVT_LSB + EV_TX_DONE]);
    // R5: each DMA fault shows next cycle
    p_dma_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_dir_err |=> status[EVT_LSB + EV_DMA_DIR]);
    // R10: events read zero in the first cycle after reset
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (status[EVT_LSB +: EVT_N] == '0 && !irq));
endmodule

// File: tb/sim_chan_status_irq.sv
`timescale 1ns/1ps
module sim_chan_status_irq;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_msg_done = 0, rx_line = 1, rx_byte_done = 0, bit_tick = 0;
    logic [CW-1:0] tx_count = 0, rx_count = 0, tx_ae_level = 3, rx_af_level = 12;
    logic          dma_tgt_abort = 0, dma_mst_abort = 0, dma_dir_err = 0;
    logic          wr_en = 0, wr_sel = 0;
    logic [15:0]   wr_data = 0;
    logic [15:0]   status;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    chan_status_irq #(.FIFO_DEPTH(DEPTH), .IDLE_BITS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_msg_done(tx_msg_done), .rx_line(rx_line),
        .rx_byte_done(rx_byte_done), .bit_tick(bit_tick), .tx_count(tx_count),
        .rx_count(rx_count), .tx_ae_level(tx_ae_level), .rx_af_level(rx_af_level),
        .dma_tgt_abort(dma_tgt_abort), .dma_mst_abort(dma_mst_abort),
        .dma_dir_err(dma_dir_err), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .status(status), .irq(irq)
    );

    // Behavioural reference state
    logic [6:0] m_ev, m_en;
    bit         m_armed, m_tx_prev, m_rx_prev;
    int         m_idle;

    always @(posedge clk) begin
        logic [6:0] s, c;
        bit fire, tl, rh;
        if (!rst_n) begin
            m_ev = 0; m_en = 0; m_armed = 0; m_idle = 0;
            m_tx_prev = 1; m_rx_prev = 1;
        end else begin
            s = 0;
            s[0] = tx_msg_done;
            fire = m_armed && rx_line && bit_tick && !rx_byte_done && (m_idle == 7);
            s[1] = fire;
            if (rx_byte_done) begin m_armed = 1; m_idle = 0; end
            else if (!rx_line) m_idle = 0;
            else if (fire) begin m_armed = 0; m_idle = 0; end
            else if (m_armed && bit_tick) m_idle++;
            tl = (int'(tx_count) <= int'(tx_ae_level));
            rh = (int'(rx_count) >= int'(rx_af_level));
            s[2] = tl && !m_tx_prev; m_tx_prev = tl;
            s[3] = rh && !m_rx_prev; m_rx_prev = rh;
            s[4] = dma_tgt_abort; s[5] = dma_mst_abort; s[6] = dma_dir_err;
            c = (wr_en && !wr_sel) ? wr_data[14:8] : 7'd0;
            m_ev = (m_ev & ~c) | s;
            if (wr_en && wr_sel) m_en = wr_data[14:8];
        end
    end

    function automatic logic [15:0] model_status();
        logic [15:0] v = 0;
        v[0] = (tx_count == 0);
        v[1] = (int'(tx_count) <= int'(tx_ae_level));
        v[2] = (rx_count == 0);
        v[3] = (int'(rx_count) >= int'(rx_af_level));
        v[4] = (int'(rx_count) == DEPTH);
        v[14:8] = m_ev;
        return v;
    endfunction

    function automatic string req_of(logic [15:0] d, bit di);
        if (d[8])       return "R1";
        if (d[9])       return "R2";
        if (d[10])      return "R3";
        if (d[11])      return "R4";
        if (|d[14:12])  return "R5";
        if (|d[7:0] || d[15]) return "R6";
        if (di)         return "R9";
        return "R10";
    endfunction

    // Per-cycle comparison against the model
    task automatic compare();
        logic [15:0] e = model_status();
        bit ei = |(m_ev & m_en);
        n_checks++;
        if (status !== e || irq !== ei) begin
            n_fail++;
            $display("FAIL %s cycle compare: status=%h exp=%h irq=%b exp=%b",
                     req_of(status ^ e, irq ^ ei), status, e, irq, ei);
        end
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            compare();
        end
    endtask

    task automatic expect_bit(string req, int pos, bit exp);
        n_checks++;
        if (status[pos] !== exp) begin
            n_fail++;
            $display("FAIL %s status[%0d]=%b exp=%b", req, pos, status[pos], exp);
        end
    endtask

    task automatic w1c(logic [15:0] d);
        wr_en = 1; wr_sel = 0; wr_data = d; cyc(); wr_en = 0; wr_data = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1; cyc(); bit_tick = 0; cyc(3);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        cyc(3);
        rst_n = 1; cyc();
        // R10 reset state
        n_checks++;
        if (status[15:8] !== 0 || irq !== 0) begin
            n_fail++; $display("FAIL R10 status=%h irq=%b exp=0", status, irq);
        end
        // R6 live flags at empty FIFOs
        expect_bit("R6", 0, 1); expect_bit("R6", 2, 1); expect_bit("R6", 3, 0);

        // R1 set, R7 write-zero keeps, write-one clears
        tx_msg_done = 1; cyc(); tx_msg_done = 0;
        expect_bit("R1", 8, 1);
        w1c(16'h0000); expect_bit("R7", 8, 1);
        w1c(16'h0100); expect_bit("R7", 8, 0);

        // R8 set and clear in the same cycle
        tx_msg_done = 1; cyc(); tx_msg_done = 0;
        tx_msg_done = 1; wr_en = 1; wr_sel = 0; wr_data = 16'h0100; cyc();
        tx_msg_done = 0; wr_en = 0; wr_data = 0;
        expect_bit("R8", 8, 1);
        w1c(16'h0100);

        // R2 idle ticks without a byte
        ticks(10); expect_bit("R2", 9, 0);
        rx_byte_done = 1; cyc(); rx_byte_done = 0;
        ticks(7); expect_bit("R2", 9, 0);
        rx_line = 0; cyc(); rx_line = 1;
        ticks(7); expect_bit("R2", 9, 0);
        ticks(1); expect_bit("R2", 9, 1);
        w1c(16'h0200);
        ticks(10); expect_bit("R2", 9, 0);

        // R3 TX count descends through the level
        tx_count = 10; cyc();
        for (int k = 9; k >= 2; k--) begin tx_count = CW'(k); cyc(); end
        expect_bit("R3", 10, 1);
        w1c(16'h0400); cyc(3); expect_bit("R3", 10, 0);
        tx_count = 6; cyc(); tx_count = 3; cyc(); expect_bit("R3", 10, 1);
        w1c(16'h0400);

        // R4 RX count ascends through the level
        for (int k = 1; k <= 14; k++) begin rx_count = CW'(k); cyc(); end
        expect_bit("R4", 11, 1);
        w1c(16'h0800); cyc(4); expect_bit("R4", 11, 0);
        rx_count = 16; cyc(); expect_bit("R6", 4, 1); expect_bit("R4", 11, 0);
        rx_count = 0; cyc();

        // R5 DMA faults
        dma_tgt_abort = 1; cyc(); dma_tgt_abort = 0; expect_bit("R5", 12, 1);
        dma_mst_abort = 1; cyc(); dma_mst_abort = 0; expect_bit("R5", 13, 1);
        dma_dir_err = 1; cyc(); dma_dir_err = 0; expect_bit("R5", 14, 1);

        // R9 masking: only bit 8 enabled
        wr_en = 1; wr_sel = 1; wr_data = 16'h0100; cyc(); wr_en = 0; wr_data = 0;
        n_checks++;
        if (irq !== 0) begin n_fail++; $display("FAIL R9 irq=%b exp=0", irq); end
        tx_msg_done = 1; cyc(); tx_msg_done = 0;
        n_checks++;
        if (irq !== 1) begin n_fail++; $display("FAIL R9 irq=%b exp=1", irq); end
        w1c(16'h7F00);
        n_checks++;
        if (irq !== 0) begin n_fail++; $display("FAIL R9 irq=%b exp=0", irq); end

        cyc(5);
        finished = 1;
        report();
    end
endmodule